// File: doc/BRIEF.md
# Power-Mode Sequencer with Debugger Power Handshake

This block steps a small microcontroller through its power modes. There are two run-class modes: full-speed run and low-power run. Each has a wait mode that gates the core clock. There are two stop modes that gate clocks, a state-retaining deep stop and a power-off stop. The core asks for a new mode by pulsing `req_valid_i` with a 3-bit mode code. A wakeup pulse moves any sleeping mode through a fixed-length wake phase. The controller then returns to the run-class mode it left, or to full-speed run after power-off.

A debugger can hold two power-up request lines, one for the system and one for debug. Each line gets its own registered acknowledge while the controller is in an acknowledging mode and the security input is low. When both lines are held and security is low, a request for either stop mode is turned into an emulated stop. In emulated stop the regulator stays in run regulation and the clock source stays on. Every clock but the core clock is gated, the debugger may reach the core registers, and peripheral access is blocked.

Mode codes, which are also the values of `mode_o`: RUN=0, WAIT=1, LPRUN=2, LPWAIT=3, STOP=4, LPSTOP=5, RETAIN=6, OFF=7, EMU (emulated stop)=8, WAKE=9. The named transitions are:
- RUN→{WAIT, LPRUN, STOP, LPSTOP, RETAIN, OFF, EMU} and LPRUN→{RUN, LPWAIT, STOP, LPSTOP, RETAIN, OFF, EMU}, taken on a request.
- {WAIT, LPWAIT, STOP, LPSTOP, RETAIN, OFF, EMU}→WAKE, taken on a wakeup.
- WAKE→home, taken when the wake timer expires.

Top module: `lpm_ctrl`

## Requirements
- R1: While and after reset, `mode_o` is RUN (0), both acknowledges are 0, `reg_run_o`=1, `clksrc_en_o`=1, both gates are 0 and `periph_block_o`=0.
- R2: In RUN, a request for codes 1, 2, 4, 5, 6 or 7 is taken at the next edge, and codes 0 and 3 are ignored. In LPRUN, codes 0, 3, 4, 5, 6 and 7 are taken, and codes 1 and 2 are ignored. Requests in any other mode are ignored.
- R3: The outputs {reg_run, clksrc_en, sysclk_gate, coreclk_gate} per mode are as follows. RUN 1100, WAIT 1101, LPRUN 0100, LPWAIT 0101, STOP 1011, LPSTOP 0011, RETAIN 0011, OFF 0011, EMU 1110, WAKE 1111. `periph_block_o` is 1 only in EMU.
- R4: `wake_i` in WAIT, LPWAIT, STOP, LPSTOP, RETAIN, OFF or EMU moves the controller to WAKE at the next edge. It is ignored in RUN and LPRUN.
- R5: Each acknowledge is 1 in the cycle after an edge at which its request was 1, the mode was RUN, WAIT, LPRUN, LPWAIT or EMU, and `secure_i` was 0. Otherwise it is 0.
- R6: If both debug requests are held and `secure_i` is 0, an accepted STOP or LPSTOP request enters EMU (8) instead.
- R7: In EMU, `reg_run_o`=1, `clksrc_en_o`=1, `sysclk_gate_o`=1, `coreclk_gate_o`=0, `periph_block_o`=1, and `dbg_core_access_o` is 1 while `secure_i` is 0.
- R8: With only one debug request held, STOP and LPSTOP are entered as real modes, and that acknowledge drops one cycle after entry.
- R9: From the second cycle in RETAIN or OFF, both acknowledges and `dbg_core_access_o` are 0. After a wake from RETAIN, the acknowledges of held requests return.
- R10: While `secure_i` is 1, `dbg_core_access_o` is 0 and no acknowledge is raised. STOP and LPSTOP requests made while it is 1 enter the real modes.
- R11: The controller stays in WAKE for exactly WAKE_CYC cycles, then enters its home mode. The home mode is the run-class mode that was left, or RUN when the wake came from OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| secure_i | input | 1 | Device secured; disables debug handshake |
| req_valid_i | input | 1 | Mode-entry request strobe from the core |
| req_mode_i | input | 3 | Requested mode code |
| wake_i | input | 1 | Wakeup event |
| sys_pwr_req_i | input | 1 | Debugger system power-up request |
| dbg_pwr_req_i | input | 1 | Debugger debug power-up request |
| sys_pwr_ack_o | output | 1 | System power-up acknowledge |
| dbg_pwr_ack_o | output | 1 | Debug power-up acknowledge |
| mode_o | output | 4 | Current mode code |
| reg_run_o | output | 1 | Regulator in run regulation |
| clksrc_en_o | output | 1 | Clock source enable |
| sysclk_gate_o | output | 1 | System clocks gated |
| coreclk_gate_o | output | 1 | Core clock gated |
| dbg_core_access_o | output | 1 | Debugger may access core registers |
| periph_block_o | output | 1 | On-chip peripheral access blocked |

## Verification
Every state of the sequencer is visible on `mode_o`, and every output is decoded from that state alone. A wrong next-state choice therefore shows on the mode code and the power outputs one edge after the request or wakeup that caused it. A corrupted home register stays hidden until the wake phase ends. It then shows as a return to the wrong run-class mode exactly WAKE_CYC cycles after the wakeup. Errors in the acknowledge path appear one cycle after the mode or request change, because the acknowledges are registered.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 4;
    localparam int REQ_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RUN    = 4'd0,
        M_WAIT   = 4'd1,
        M_LPRUN  = 4'd2,
        M_LPWAIT = 4'd3,
        M_STOP   = 4'd4,
        M_LPSTOP = 4'd5,
        M_RETAIN = 4'd6,
        M_OFF    = 4'd7,
        M_EMU    = 4'd8,
        M_WAKE   = 4'd9
    } lpm_mode_e;

    typedef struct packed {
        logic reg_run;
        logic clksrc_en;
        logic sysclk_gate;
        logic coreclk_gate;
        logic dbg_access;
        logic periph_block;
    } lpm_ctl_s;

    // Whether a run-class mode may move to the requested mode.
    function automatic logic accept_req(lpm_mode_e base, lpm_mode_e tgt);
        logic ok;
        unique case (tgt)
            M_RUN:    ok = (base == M_LPRUN);
            M_WAIT:   ok = (base == M_RUN);
            M_LPRUN:  ok = (base == M_RUN);
            M_LPWAIT: ok = (base == M_LPRUN);
            M_STOP, M_LPSTOP, M_RETAIN, M_OFF: ok = 1'b1;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic is_stop_req(lpm_mode_e tgt);
        return (tgt == M_STOP) || (tgt == M_LPSTOP);
    endfunction

    // Modes in which the debugger handshake is served.
    function automatic logic ack_mode(lpm_mode_e m);
        return (m == M_RUN) || (m == M_WAIT) || (m == M_LPRUN) ||
               (m == M_LPWAIT) || (m == M_EMU);
    endfunction

endpackage

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAKE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [REQ_W-1:0] req_mode_i,
    input  logic             wake_i,
    input  logic             emu_ok_i,
    input  logic             wake_done_i,
    output lpm_mode_e        state_o,
    output logic             wake_load_o
);
    lpm_mode_e state_q, state_d;
    lpm_mode_e home_q, home_d;
    lpm_mode_e tgt;

    assign tgt = lpm_mode_e'({1'b0, req_mode_i});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_RUN;
            home_q  <= M_RUN;
        end else begin
            state_q <= state_d;
            home_q  <= home_d;
        end
    end

    always_comb begin
        state_d = state_q;
        home_d  = home_q;
        unique case (state_q)
            M_RUN, M_LPRUN: begin
                home_d = state_q;
                if (req_valid_i && accept_req(state_q, tgt)) begin
                    state_d = (emu_ok_i && is_stop_req(tgt)) ? M_EMU : tgt;
                end
            end
            M_WAIT, M_LPWAIT, M_STOP, M_LPSTOP, M_RETAIN, M_EMU: begin
                if (wake_i) state_d = M_WAKE;
            end
            M_OFF: begin
                if (wake_i) begin
                    state_d = M_WAKE;
                    home_d  = M_RUN;
                end
            end
            M_WAKE: begin
                if (wake_done_i) state_d = home_q;
            end
            default: state_d = M_RUN;
        endcase
    end

    assign state_o     = state_q;
    assign wake_load_o = (state_d == M_WAKE) && (state_q != M_WAKE);
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
    import lpm_pkg::*;
(
    input  lpm_mode_e state_i,
    input  logic      secure_i,
    output lpm_ctl_s  ctl_o
);
    lpm_ctl_s base;

    always_comb begin
        base = '0;
        unique case (state_i)
            M_RUN:    base = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            M_WAIT:   base = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            M_LPRUN:  base = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            M_LPWAIT: base = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            M_STOP:   base = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            M_LPSTOP: base = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            M_RETAIN: base = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            M_OFF:    base = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
            M_EMU:    base = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
            M_WAKE:   base = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
            default:  base = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        endcase
        ctl_o = base;
        ctl_o.dbg_access = base.dbg_access & ~secure_i;
    end
endmodule

// File: rtl/lpm_dbg_ack.sv
module lpm_dbg_ack #(
    parameter int N_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_i,
    input  logic               allow_i,
    output logic [N_LINES-1:0] ack_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic ack_q;
        always_ff @(posedge clk) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= req_i[i] & allow_i;
        end
        assign ack_o[i] = ack_q;
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              secure_i,
    input  logic              req_valid_i,
    input  logic [REQ_W-1:0]  req_mode_i,
    input  logic              wake_i,
    input  logic              sys_pwr_req_i,
    input  logic              dbg_pwr_req_i,
    output logic              sys_pwr_ack_o,
    output logic              dbg_pwr_ack_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              reg_run_o,
    output logic              clksrc_en_o,
    output logic              sysclk_gate_o,
    output logic              coreclk_gate_o,
    output logic              dbg_core_access_o,
    output logic              periph_block_o
);
    lpm_mode_e  state;
    logic       wake_load;
    logic       wake_done;
    logic       emu_ok;
    logic       ack_allow;
    logic [1:0] ack;
    lpm_ctl_s   ctl;

    assign emu_ok    = sys_pwr_req_i & dbg_pwr_req_i & ~secure_i;
    assign ack_allow = ack_mode(state) & ~secure_i;

    lpm_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_mode_i  (req_mode_i),
        .wake_i      (wake_i),
        .emu_ok_i    (emu_ok),
        .wake_done_i (wake_done),
        .state_o     (state),
        .wake_load_o (wake_load)
    );

    lpm_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wake_load),
        .done_o (wake_done)
    );

    lpm_dbg_ack #(.N_LINES(2)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   ({dbg_pwr_req_i, sys_pwr_req_i}),
        .allow_i (ack_allow),
        .ack_o   (ack)
    );

    lpm_out_decode u_dec (
        .state_i  (state),
        .secure_i (secure_i),
        .ctl_o    (ctl)
    );

    assign sys_pwr_ack_o     = ack[0];
    assign dbg_pwr_ack_o     = ack[1];
    assign mode_o            = state;
    assign reg_run_o         = ctl.reg_run;
    assign clksrc_en_o       = ctl.clksrc_en;
    assign sysclk_gate_o     = ctl.sysclk_gate;
    assign coreclk_gate_o    = ctl.coreclk_gate;
    assign dbg_core_access_o = ctl.dbg_access;
    assign periph_block_o    = ctl.periph_block;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       secure_i,
    input logic       req_valid_i,
    input logic       wake_i,
    input logic       sys_pwr_req_i,
    input logic       dbg_pwr_req_i,
    input logic       sys_pwr_ack_o,
    input logic       dbg_pwr_ack_o,
    input logic [3:0] mode_o,
    input logic       reg_run_o,
    input logic       clksrc_en_o,
    input logic       sysclk_gate_o,
    input logic       coreclk_gate_o,
    input logic       dbg_core_access_o,
    input logic       periph_block_o
);
    logic seen_q;
    logic ackm;
    logic deep_now;
    logic exp_sys, exp_dbg;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign ackm     = (mode_o <= 4'd3) || (mode_o == 4'd8);
    assign deep_now = (mode_o == 4'd6) || (mode_o == 4'd7);
    assign exp_sys  = sys_pwr_req_i && ackm && !secure_i;
    assign exp_dbg  = dbg_pwr_req_i && ackm && !secure_i;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mode_o == 4'd0 && !sys_pwr_ack_o && !dbg_pwr_ack_o &&
                    reg_run_o && clksrc_en_o && !sysclk_gate_o &&
                    !coreclk_gate_o && !periph_block_o));

    a_r2_leave_run_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(mode_o) == 4'd0 && mode_o != 4'd0) |-> $past(req_valid_i));

    a_r4_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_o == 4'd9 && $past(mode_o) != 4'd9) |-> $past(wake_i));

    a_r5_sys_ack: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (sys_pwr_ack_o == $past(exp_sys)));

    a_r5_dbg_ack: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (dbg_pwr_ack_o == $past(exp_dbg)));

    a_r6_emu_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_o == 4'd8 && $past(mode_o) != 4'd8) |->
        $past(sys_pwr_req_i && dbg_pwr_req_i && !secure_i));

    a_r7_emu_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 4'd8) |-> (reg_run_o && clksrc_en_o && sysclk_gate_o &&
                              !coreclk_gate_o && periph_block_o));

    a_r9_deep_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && deep_now && ($past(mode_o) == 4'd6 || $past(mode_o) == 4'd7)) |->
        (!sys_pwr_ack_o && !dbg_pwr_ack_o && !dbg_core_access_o));

    a_r10_secure_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        secure_i |-> !dbg_core_access_o);

    a_r10_secure_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(secure_i)) |-> (!sys_pwr_ack_o && !dbg_pwr_ack_o));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .secure_i          (secure_i),
    .req_valid_i       (req_valid_i),
    .wake_i            (wake_i),
    .sys_pwr_req_i     (sys_pwr_req_i),
    .dbg_pwr_req_i     (dbg_pwr_req_i),
    .sys_pwr_ack_o     (sys_pwr_ack_o),
    .dbg_pwr_ack_o     (dbg_pwr_ack_o),
    .mode_o            (mode_o),
    .reg_run_o         (reg_run_o),
    .clksrc_en_o       (clksrc_en_o),
    .sysclk_gate_o     (sysclk_gate_o),
    .coreclk_gate_o    (coreclk_gate_o),
    .dbg_core_access_o (dbg_core_access_o),
    .periph_block_o    (periph_block_o)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE_CYC   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       secure_i = 1'b0;
    logic       req_valid_i = 1'b0;
    logic [2:0] req_mode_i = 3'd0;
    logic       wake_i = 1'b0;
    logic       sys_pwr_req_i = 1'b0;
    logic       dbg_pwr_req_i = 1'b0;
    logic       sys_pwr_ack_o, dbg_pwr_ack_o;
    logic [3:0] mode_o;
    logic       reg_run_o, clksrc_en_o, sysclk_gate_o, coreclk_gate_o;
    logic       dbg_core_access_o, periph_block_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl #(.WAKE_CYC(WAKE_CYC)) i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .secure_i(secure_i),
        .req_valid_i(req_valid_i), .req_mode_i(req_mode_i), .wake_i(wake_i),
        .sys_pwr_req_i(sys_pwr_req_i), .dbg_pwr_req_i(dbg_pwr_req_i),
        .sys_pwr_ack_o(sys_pwr_ack_o), .dbg_pwr_ack_o(dbg_pwr_ack_o),
        .mode_o(mode_o), .reg_run_o(reg_run_o), .clksrc_en_o(clksrc_en_o),
        .sysclk_gate_o(sysclk_gate_o), .coreclk_gate_o(coreclk_gate_o),
        .dbg_core_access_o(dbg_core_access_o), .periph_block_o(periph_block_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // {reg_run, clksrc, sysgate, coregate} per mode code, from R3.
    function automatic int pwr_bits(input int m);
        case (m)
            0: return 4'b1100;
            1: return 4'b1101;
            2: return 4'b0100;
            3: return 4'b0101;
            4: return 4'b1011;
            5, 6, 7: return 4'b0011;
            8: return 4'b1110;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic bit is_ack_mode(input int m);
        return (m <= 3) || (m == 8);
    endfunction

    function automatic int next_mode(input int b, input int c, input int d, input bit s);
        bit ok;
        if (b == 0) ok = (c == 1) || (c == 2) || (c >= 4);
        else        ok = (c == 0) || (c == 3) || (c >= 4);
        if (!ok) return b;
        if ((c == 4 || c == 5) && d == 3 && !s) return 8;
        return c;
    endfunction

    function automatic int cur_pwr();
        return {reg_run_o, clksrc_en_o, sysclk_gate_o, coreclk_gate_o};
    endfunction

    task automatic check_outputs(input int m, input bit s);
        check("R3 power outputs", cur_pwr(), pwr_bits(m));
        check("R3 periph block", periph_block_o, (m == 8) ? 1 : 0);
        check("R10 dbg access", dbg_core_access_o, (is_ack_mode(m) && !s) ? 1 : 0);
        if (m == 8) check("R7 emu dbg access", dbg_core_access_o, s ? 0 : 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid_i = 1'b0; wake_i = 1'b0;
        secure_i = 1'b0; sys_pwr_req_i = 1'b0; dbg_pwr_req_i = 1'b0;
        tick(); tick();
        check("R1 mode", mode_o, 0);
        check("R1 acks", {sys_pwr_ack_o, dbg_pwr_ack_o}, 0);
        check("R1 power outputs", cur_pwr(), 4'b1100);
        check("R1 periph block", periph_block_o, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int b = 0; b <= 2; b += 2) begin
            for (int c = 0; c < 8; c++) begin
                for (int d = 0; d < 4; d++) begin
                    for (int si = 0; si < 2; si++) begin
                        automatic bit s = si[0];
                        automatic int ex;
                        automatic int ack_exp;
                        do_reset();
                        secure_i = s;
                        sys_pwr_req_i = d[0];
                        dbg_pwr_req_i = d[1];
                        ack_exp = s ? 0 : d;
                        if (b == 2) begin
                            req_valid_i = 1'b1; req_mode_i = 3'd2;
                            tick();
                            req_valid_i = 1'b0;
                            check("R2 enter LPRUN", mode_o, 2);
                        end
                        tick();
                        check("R5 acks in run", {dbg_pwr_ack_o, sys_pwr_ack_o}, ack_exp);
                        if (s) check("R10 no ack when secure", {dbg_pwr_ack_o, sys_pwr_ack_o}, 0);
                        req_valid_i = 1'b1; req_mode_i = c[2:0];
                        tick();
                        req_valid_i = 1'b0;
                        ex = next_mode(b, c, d, s);
                        if (ex == 8) check("R6 emulated stop", mode_o, 8);
                        else if ((c == 4 || c == 5) && ex == c && d != 3)
                            check("R8 real stop", mode_o, ex);
                        else if (s && (c == 4 || c == 5) && ex == c)
                            check("R10 real stop when secure", mode_o, ex);
                        else check("R2 next mode", mode_o, ex);
                        check_outputs(ex, s);
                        tick();
                        check("R5 acks after entry", {dbg_pwr_ack_o, sys_pwr_ack_o},
                              is_ack_mode(ex) ? ack_exp : 0);
                        if (ex == 6 || ex == 7)
                            check("R9 deep silent", {dbg_pwr_ack_o, sys_pwr_ack_o, dbg_core_access_o}, 0);
                        if (ex == 0 || ex == 2) begin
                            wake_i = 1'b1;
                            tick();
                            wake_i = 1'b0;
                            check("R4 wake ignored in run-class", mode_o, ex);
                        end else begin
                            req_valid_i = 1'b1; req_mode_i = 3'd0;
                            tick();
                            req_valid_i = 1'b0;
                            check("R2 request ignored while asleep", mode_o, ex);
                            wake_i = 1'b1;
                            tick();
                            wake_i = 1'b0;
                            check("R4 enter wake", mode_o, 9);
                            check_outputs(9, s);
                            for (int k = 1; k < WAKE_CYC; k++) begin
                                tick();
                                check("R11 wake length", mode_o, 9);
                            end
                            tick();
                            check("R11 home mode", mode_o, (ex == 7) ? 0 : b);
                            tick();
                            if (ex == 6)
                                check("R9 acks resume after retain", {dbg_pwr_ack_o, sys_pwr_ack_o}, ack_exp);
                            else
                                check("R5 acks after wake", {dbg_pwr_ack_o, sys_pwr_ack_o}, ack_exp);
                        end
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule